// File: doc/BRIEF.md
# Interrupt Command Queue Consumer

This block drains a circular command queue that software keeps in memory for a message-based interrupt translation unit. Software supplies the queue base address, a page count in 4 KiB pages (written as count minus one), a producer (write) offset and, through a load strobe, a consumer (read) offset. Offsets count whole 32-byte entries. The block works out how many entries fit in the programmed pages and checks both offsets against that number. While the queue is enabled, both offsets are in range and the queue is not empty, the block fetches the entry at the read offset over a simple request/response memory port. It passes the entry to an external command executor and waits for the executor's verdict.

A completed or dropped command moves the read offset forward by one, wrapping to zero at the capacity. A stall or fatal verdict freezes the read offset and parks the block until software reloads the read offset. Decoding and executing commands, and the memory fabric, are outside this block.

Top module: `cmdq_consumer`

## Requirements
- R1: Capacity in entries is (cfg_pages_m1 + 1) * 4096 / 32, that is 128 entries per programmed page.
- R2: While cfg_valid is high, err_wr_off is high exactly when cfg_wr_off is greater than or equal to the capacity, and no fetch starts while it is high.
- R3: While cfg_valid is high, err_rd_off is high exactly when rd_off is greater than or equal to the capacity, and no fetch starts while it is high.
- R4: No fetch starts while cfg_valid is low, while rd_off equals cfg_wr_off (queue empty), or in a cycle with rd_load high.
- R5: A fetch raises mem_req_valid with mem_req_addr = cfg_base + rd_off * 32, and holds both until mem_req_ready is high.
- R6: The data returned with mem_rsp_valid is presented on exe_cmd with exe_valid held, unchanged, until exe_done is high.
- R7: exe_result 2'b00 (done) advances rd_off by one, and rd_off wraps to 0 when the incremented value equals the capacity.
- R8: exe_result 2'b01 (dropped for bad parameters) advances rd_off exactly as R7 does, and processing continues with the next entry.
- R9: exe_result 2'b10 (stall) or 2'b11 (fatal) leaves rd_off unchanged and raises stalled. While stalled, no fetch or execute request is issued until rd_load is applied.
- R10: rd_load writes rd_load_val into rd_off only when the block is idle or stalled. During a fetch or execute it is ignored.
- R11: After reset, rd_off is 0, stalled is low and neither mem_req_valid nor exe_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Queue enable |
| cfg_base | input | ADDR_W | Byte address of the first queue entry |
| cfg_pages_m1 | input | PAGE_W | Number of 4 KiB pages minus one |
| cfg_wr_off | input | OFF_W | Producer offset in entries |
| rd_load | input | 1 | Load strobe for the read offset |
| rd_load_val | input | OFF_W | Value loaded into the read offset |
| rd_off | output | OFF_W | Current read offset in entries |
| err_wr_off | output | 1 | Write offset out of range |
| err_rd_off | output | 1 | Read offset out of range |
| stalled | output | 1 | Executor stall or fatal verdict pending |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Request byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | CMD_W | One command entry |
| exe_valid | output | 1 | Command offered to the executor |
| exe_cmd | output | CMD_W | Command entry |
| exe_done | input | 1 | Executor verdict valid |
| exe_result | input | 2 | Verdict: 00 done, 01 dropped, 10 stall, 11 fatal |

## Verification
The assertions check on every cycle that a fetch begins only when the enable, both range checks and the non-empty condition held in the cycle before. They also check that a pending request or command stays stable, that the read offset only ever steps by one or wraps to zero unless loaded, and that a stalled block stays quiet with a frozen offset. Only the bench's scenarios can show the capacity arithmetic at page boundaries, the full wrap from the last entry to entry zero, the effect of each executor verdict on how many commands are consumed, and that a reload ignored in mid-command leaves no trace.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  typedef enum logic [1:0] {
    RES_DONE  = 2'b00,
    RES_DROP  = 2'b01,
    RES_STALL = 2'b10,
    RES_FATAL = 2'b11
  } exe_res_e;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_REQ   = 3'd1,
    SQ_RSP   = 3'd2,
    SQ_EXE   = 3'd3,
    SQ_STALL = 3'd4
  } seq_state_e;

  localparam int PAGE_BYTES_LOG2 = 12;

endpackage

// File: rtl/cmdq_rst_sync.sv
module cmdq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/cmdq_capacity.sv
module cmdq_capacity #(
  parameter int PAGE_W   = 8,
  parameter int PG_SHIFT = 7,
  parameter int OFF_W    = PAGE_W + PG_SHIFT,
  parameter int CNT_W    = OFF_W + 1
) (
  input  logic              q_enable,
  input  logic [PAGE_W-1:0] pages_m1,
  input  logic [OFF_W-1:0]  prod_off,
  input  logic [OFF_W-1:0]  cons_off,
  output logic [CNT_W-1:0]  num_entries,
  output logic              prod_bad,
  output logic              cons_bad
);

  logic [PAGE_W:0] page_cnt;

  assign page_cnt = {1'b0, pages_m1} + {{PAGE_W{1'b0}}, 1'b1};

  generate
    if (PG_SHIFT == 0) begin : g_noshift
      assign num_entries = page_cnt;
    end else begin : g_shift
      assign num_entries = {page_cnt, {PG_SHIFT{1'b0}}};
    end
  endgenerate

  always_comb begin
    prod_bad = q_enable && ({1'b0, prod_off} >= num_entries);
    cons_bad = q_enable && ({1'b0, cons_off} >= num_entries);
  end

endmodule

// File: rtl/cmdq_rdptr.sv
module cmdq_rdptr #(
  parameter int OFF_W = 15,
  parameter int CNT_W = OFF_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [OFF_W-1:0] load_val,
  input  logic             step_en,
  input  logic [CNT_W-1:0] num_entries,
  output logic [OFF_W-1:0] ptr
);

  logic [OFF_W-1:0] ptr_q;
  logic [OFF_W-1:0] ptr_d;
  logic [CNT_W-1:0] ptr_inc;
  logic             at_end;
  logic             ptr_en;

  assign ptr_inc = {1'b0, ptr_q} + {{(CNT_W-1){1'b0}}, 1'b1};
  assign at_end  = (ptr_inc == num_entries);
  assign ptr_en  = load_en || step_en;

  always_comb begin
    ptr_d = ptr_q;
    if (load_en) begin
      ptr_d = load_val;
    end else if (step_en) begin
      ptr_d = at_end ? '0 : ptr_inc[OFF_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/cmdq_seq.sv
module cmdq_seq
  import cmdq_pkg::*;
#(
  parameter int CMD_W = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_ok,
  input  logic             sw_load,
  input  logic             req_ready,
  input  logic             rsp_valid,
  input  logic [CMD_W-1:0] rsp_data,
  input  logic             done,
  input  logic [1:0]       verdict,
  output logic             req_valid,
  output logic             cmd_valid,
  output logic [CMD_W-1:0] cmd,
  output logic             ptr_step,
  output logic             load_ok,
  output logic             parked
);

  seq_state_e       state_q, state_d;
  logic [CMD_W-1:0] cmd_q;
  logic             cmd_en;
  logic             verdict_moves;

  assign verdict_moves = (verdict == RES_DONE) || (verdict == RES_DROP);

  always_comb begin
    state_d  = state_q;
    cmd_en   = 1'b0;
    ptr_step = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (start_ok && !sw_load) state_d = SQ_REQ;
      end
      SQ_REQ: begin
        if (req_ready) state_d = SQ_RSP;
      end
      SQ_RSP: begin
        if (rsp_valid) begin
          cmd_en  = 1'b1;
          state_d = SQ_EXE;
        end
      end
      SQ_EXE: begin
        if (done) begin
          if (verdict_moves) begin
            ptr_step = 1'b1;
            state_d  = SQ_IDLE;
          end else begin
            state_d  = SQ_STALL;
          end
        end
      end
      SQ_STALL: begin
        if (sw_load) state_d = SQ_IDLE;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (cmd_en) begin
      cmd_q <= rsp_data;
    end
  end

  assign req_valid = (state_q == SQ_REQ);
  assign cmd_valid = (state_q == SQ_EXE);
  assign parked    = (state_q == SQ_STALL);
  assign load_ok   = (state_q == SQ_IDLE) || (state_q == SQ_STALL);
  assign cmd       = cmd_q;

endmodule

// File: rtl/cmdq_consumer.sv
module cmdq_consumer
  import cmdq_pkg::*;
#(
  parameter int  ADDR_W     = 48,
  parameter int  PAGE_W     = 8,
  parameter int  ENTRY_LOG2 = 5,
  localparam int PG_SHIFT   = PAGE_BYTES_LOG2 - ENTRY_LOG2,
  localparam int OFF_W      = PAGE_W + PG_SHIFT,
  localparam int CNT_W      = OFF_W + 1,
  localparam int CMD_W      = 8 << ENTRY_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [PAGE_W-1:0] cfg_pages_m1,
  input  logic [OFF_W-1:0]  cfg_wr_off,
  input  logic              rd_load,
  input  logic [OFF_W-1:0]  rd_load_val,
  output logic [OFF_W-1:0]  rd_off,
  output logic              err_wr_off,
  output logic              err_rd_off,
  output logic              stalled,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [CMD_W-1:0]  mem_rsp_data,
  output logic              exe_valid,
  output logic [CMD_W-1:0]  exe_cmd,
  input  logic              exe_done,
  input  logic [1:0]        exe_result
);

  logic             rst_n_int;
  logic [CNT_W-1:0] num_entries;
  logic             wr_bad;
  logic             rd_bad;
  logic             start_ok;
  logic             step;
  logic             load_ok;
  logic             load_fire;
  logic [OFF_W-1:0] rd_q;

  cmdq_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  cmdq_capacity #(
    .PAGE_W   (PAGE_W),
    .PG_SHIFT (PG_SHIFT),
    .OFF_W    (OFF_W),
    .CNT_W    (CNT_W)
  ) u_capacity (
    .q_enable    (cfg_valid),
    .pages_m1    (cfg_pages_m1),
    .prod_off    (cfg_wr_off),
    .cons_off    (rd_q),
    .num_entries (num_entries),
    .prod_bad    (wr_bad),
    .cons_bad    (rd_bad)
  );

  assign start_ok  = cfg_valid && !wr_bad && !rd_bad && (rd_q != cfg_wr_off);
  assign load_fire = rd_load && load_ok;

  cmdq_rdptr #(
    .OFF_W (OFF_W),
    .CNT_W (CNT_W)
  ) u_rdptr (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .load_en     (load_fire),
    .load_val    (rd_load_val),
    .step_en     (step),
    .num_entries (num_entries),
    .ptr         (rd_q)
  );

  cmdq_seq #(
    .CMD_W (CMD_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .start_ok  (start_ok),
    .sw_load   (rd_load),
    .req_ready (mem_req_ready),
    .rsp_valid (mem_rsp_valid),
    .rsp_data  (mem_rsp_data),
    .done      (exe_done),
    .verdict   (exe_result),
    .req_valid (mem_req_valid),
    .cmd_valid (exe_valid),
    .cmd       (exe_cmd),
    .ptr_step  (step),
    .load_ok   (load_ok),
    .parked    (stalled)
  );

  assign mem_req_addr = cfg_base + (ADDR_W'(rd_q) << ENTRY_LOG2);
  assign rd_off       = rd_q;
  assign err_wr_off   = wr_bad;
  assign err_rd_off   = rd_bad;

endmodule

// File: rtl/cmdq_consumer_chk.sv
module cmdq_consumer_chk #(
  parameter int ADDR_W = 48,
  parameter int OFF_W  = 15,
  parameter int CMD_W  = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_valid,
  input logic [OFF_W-1:0]  cfg_wr_off,
  input logic              rd_load,
  input logic [OFF_W-1:0]  rd_off,
  input logic              err_wr_off,
  input logic              err_rd_off,
  input logic              stalled,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              exe_valid,
  input logic [CMD_W-1:0]  exe_cmd,
  input logic              exe_done
);

  AST_START_WR_OK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> !$past(err_wr_off)); // R2

  AST_START_RD_OK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> !$past(err_rd_off)); // R3

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> ($past(cfg_valid) && !$past(rd_load) &&
                              ($past(rd_off) != $past(cfg_wr_off)))); // R4

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R5

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_valid && !exe_done) |=> (exe_valid && $stable(exe_cmd))); // R6

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_off != $past(rd_off)) && !$past(rd_load)) |->
      ((rd_off == OFF_W'($past(rd_off) + 1'b1)) || (rd_off == '0))); // R7

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |-> (!mem_req_valid && !exe_valid)); // R9

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (stalled && !rd_load) |=> $stable(rd_off)); // R9

  AST_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && rd_load) |=> $stable(rd_off)); // R10

endmodule

bind cmdq_consumer cmdq_consumer_chk #(
  .ADDR_W (ADDR_W),
  .OFF_W  (OFF_W),
  .CMD_W  (CMD_W)
) i_cmdq_consumer_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_valid     (cfg_valid),
  .cfg_wr_off    (cfg_wr_off),
  .rd_load       (rd_load),
  .rd_off        (rd_off),
  .err_wr_off    (err_wr_off),
  .err_rd_off    (err_rd_off),
  .stalled       (stalled),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .exe_valid     (exe_valid),
  .exe_cmd       (exe_cmd),
  .exe_done      (exe_done)
);

// File: tb/test_cmdq_consumer.sv
module test_cmdq_consumer;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 48;
  localparam int PAGE_W = 8;
  localparam int OFF_W  = 15;
  localparam int CMD_W  = 256;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_valid;
  logic [ADDR_W-1:0] cfg_base;
  logic [PAGE_W-1:0] cfg_pages_m1;
  logic [OFF_W-1:0]  cfg_wr_off;
  logic              rd_load;
  logic [OFF_W-1:0]  rd_load_val;
  logic [OFF_W-1:0]  rd_off;
  logic              err_wr_off, err_rd_off, stalled;
  logic              mem_req_valid, mem_req_ready;
  logic [ADDR_W-1:0] mem_req_addr;
  logic              mem_rsp_valid;
  logic [CMD_W-1:0]  mem_rsp_data;
  logic              exe_valid;
  logic [CMD_W-1:0]  exe_cmd;
  logic              exe_done;
  logic [1:0]        exe_result;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdq_consumer i_cmdq_consumer (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_base(cfg_base),
    .cfg_pages_m1(cfg_pages_m1), .cfg_wr_off(cfg_wr_off), .rd_load(rd_load),
    .rd_load_val(rd_load_val), .rd_off(rd_off), .err_wr_off(err_wr_off),
    .err_rd_off(err_rd_off), .stalled(stalled), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .exe_valid(exe_valid), .exe_cmd(exe_cmd), .exe_done(exe_done),
    .exe_result(exe_result)
  );

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  int phase = 0;      // 0 idle, 1 fetch, 2 wait data, 3 execute, 4 parked
  int m_rd = 0;
  int exe_seen = 0;
  int verdicts[$];
  logic [ADDR_W-1:0] rsp_addr;

  function automatic logic [CMD_W-1:0] pattern(logic [ADDR_W-1:0] a);
    return {8{a[31:0] ^ 32'h5A3C_0000}};
  endfunction

  function automatic int capacity();
    return (int'(cfg_pages_m1) + 1) * 4096 / 32;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model, advanced on each rising edge with the inputs of that edge.
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      phase = 0;
      m_rd  = 0;
    end else begin
      int  cap;
      bit  open;
      cap  = capacity();
      open = cfg_valid && (int'(cfg_wr_off) < cap) && (m_rd < cap) &&
             (m_rd != int'(cfg_wr_off)) && !rd_load;
      case (phase)
        0: if (rd_load) m_rd = int'(rd_load_val);
           else if (open) phase = 1;
        1: if (mem_req_ready) begin phase = 2; rsp_addr = mem_req_addr; end
        2: if (mem_rsp_valid) phase = 3;
        3: if (exe_done) begin
             if (exe_result < 2) begin m_rd = (m_rd + 1) % cap; phase = 0; end
             else phase = 4;
           end
        4: if (rd_load) begin m_rd = int'(rd_load_val); phase = 0; end
        default: phase = 0;
      endcase
    end
  end

  // Compare on every falling edge, then act as memory and executor.
  always @(negedge clk) begin
    if (rst_n && cycles > 0) begin
      int cap;
      logic [ADDR_W-1:0] exp_addr;
      cap = capacity();
      exp_addr = cfg_base + ADDR_W'(m_rd) * 32;
      check(int'(rd_off) == m_rd, "R7", "rd_off", rd_off, m_rd);
      check(stalled == (phase == 4), "R9", "stalled", stalled, phase == 4);
      check(mem_req_valid == (phase == 1), "R4", "mem_req_valid", mem_req_valid, phase == 1);
      check(exe_valid == (phase == 3), "R6", "exe_valid", exe_valid, phase == 3);
      check(err_wr_off == (cfg_valid && int'(cfg_wr_off) >= cap), "R2", "err_wr_off",
            err_wr_off, cfg_valid && int'(cfg_wr_off) >= cap);
      check(err_rd_off == (cfg_valid && m_rd >= cap), "R3", "err_rd_off",
            err_rd_off, cfg_valid && m_rd >= cap);
      if (phase == 1)
        check(mem_req_addr == exp_addr, "R5", "mem_req_addr", mem_req_addr, exp_addr);
      if (phase == 3)
        check(exe_cmd == pattern(exp_addr), "R6", "exe_cmd", exe_cmd[31:0], pattern(exp_addr) & 32'hFFFF_FFFF);
    end
    mem_req_ready = mem_req_valid;
    mem_rsp_valid = (phase == 2);
    mem_rsp_data  = pattern(rsp_addr);
    if (exe_valid && !exe_done) begin
      exe_seen++;
      exe_result = (verdicts.size() > 0) ? 2'(verdicts.pop_front()) : 2'b00;
    end
    exe_done = exe_valid;
  end

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 150000) begin
        check(0, "R0", "watchdog", cycles, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic load_rd(int v);
    step(1);
    rd_load = 1'b1;
    rd_load_val = OFF_W'(v);
    step(1);
    rd_load = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cfg_valid = 1'b0; cfg_base = 48'h0001_0000; cfg_pages_m1 = '0;
    cfg_wr_off = '0; rd_load = 1'b0; rd_load_val = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    exe_done = 1'b0; exe_result = 2'b00; rsp_addr = '0;
    step(3);
    rst_n = 1'b1;
    step(5);
    // R11 reset state
    check(rd_off == 0 && !stalled && !mem_req_valid && !exe_valid, "R11", "reset state",
          {rd_off, stalled, mem_req_valid, exe_valid}, 0);

    // Basic run of three commands
    cfg_wr_off = 15'd3; cfg_valid = 1'b1;
    step(30);
    check(rd_off == 3, "R7", "rd after 3 cmds", rd_off, 3);
    check(exe_seen == 3, "R6", "commands executed", exe_seen, 3);

    // Wrap from the last entry of one page to entry 0
    cfg_valid = 1'b0;
    load_rd(126);
    cfg_wr_off = 15'd1; cfg_valid = 1'b1;
    step(30);
    check(rd_off == 1, "R7", "rd after wrap", rd_off, 1);
    check(exe_seen == 6, "R7", "wrap commands", exe_seen, 6);

    // Write offset equal to capacity is rejected; one more page accepts it
    cfg_wr_off = 15'd128;
    step(2);
    check(err_wr_off == 1'b1, "R1", "128 entries in 1 page", err_wr_off, 1);
    step(20);
    check(rd_off == 1 && exe_seen == 6, "R2", "no fetch on bad wr", rd_off, 1);
    cfg_pages_m1 = 8'd1;
    step(2);
    check(err_wr_off == 1'b0, "R1", "256 entries in 2 pages", err_wr_off, 0);
    step(600);
    check(rd_off == 128, "R1", "rd after 127 cmds", rd_off, 128);
    check(exe_seen == 133, "R1", "commands executed", exe_seen, 133);

    // Read offset out of range
    cfg_valid = 1'b0; cfg_pages_m1 = 8'd0;
    load_rd(200);
    cfg_wr_off = 15'd5; cfg_valid = 1'b1;
    step(2);
    check(err_rd_off == 1'b1, "R3", "err_rd_off", err_rd_off, 1);
    step(20);
    check(rd_off == 200 && exe_seen == 133, "R3", "no fetch on bad rd", rd_off, 200);
    cfg_pages_m1 = 8'd1;
    step(300);
    check(rd_off == 5, "R3", "rd after recovery", rd_off, 5);
    check(exe_seen == 194, "R7", "commands executed", exe_seen, 194);

    // Dropped commands still advance
    cfg_valid = 1'b0;
    load_rd(10);
    verdicts.push_back(1); verdicts.push_back(0); verdicts.push_back(1);
    cfg_wr_off = 15'd13; cfg_valid = 1'b1;
    step(30);
    check(rd_off == 13, "R8", "rd after drops", rd_off, 13);
    check(exe_seen == 197, "R8", "commands executed", exe_seen, 197);

    // Stall and fatal verdicts park the block
    cfg_valid = 1'b0;
    load_rd(20);
    verdicts.push_back(0); verdicts.push_back(2);
    cfg_wr_off = 15'd25; cfg_valid = 1'b1;
    step(40);
    check(stalled == 1'b1, "R9", "stalled after stall", stalled, 1);
    check(rd_off == 21 && exe_seen == 199, "R9", "rd frozen", rd_off, 21);
    verdicts.push_back(3);
    load_rd(21);
    step(30);
    check(stalled == 1'b1 && rd_off == 21, "R9", "fatal parks", rd_off, 21);
    load_rd(21);
    step(40);
    check(!stalled && rd_off == 25, "R9", "resume after load", rd_off, 25);
    check(exe_seen == 204, "R9", "commands executed", exe_seen, 204);

    // Disabled queue does nothing
    cfg_valid = 1'b0; cfg_wr_off = 15'd30;
    step(30);
    check(rd_off == 25 && exe_seen == 204, "R4", "disabled queue idle", rd_off, 25);

    // Load during a fetch is ignored
    cfg_valid = 1'b1;
    wait (mem_req_valid);
    load_rd(5);
    step(40);
    check(rd_off == 30, "R10", "load ignored while busy", rd_off, 30);
    check(exe_seen == 209, "R10", "commands executed", exe_seen, 209);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule